// File: doc/BRIEF.md
# SDRAM Configuration and Refresh Timer

This block holds the configuration of a single-data-rate x16 SDRAM controller and generates the timing events that follow from it. Software writes one 32-bit configuration word. From that word the block runs a periodic refresh interval counter, times the power-up, precharge and auto-refresh waits that a command sequencer asks for, and moves the memory into and out of self-refresh on request. It also passes the memory-size code on to the address decoder.

The wait lengths are not fixed cycle counts. A 2-bit clock-frequency range code selects them, and each wait is sized for the highest frequency in its range, so it never falls short of the required time. The refresh interval does not depend on that code: it is a separately programmed count in interface clocks. Whenever the interface mode selection input changes value, the whole block returns to its reset state.

Top module: `sdram_cfg_timer`

## Requirements
- R1: After reset the configuration word reads 0x82EE0000. Field positions: frequency range in bits 31:30, refresh count in bits 26:16, sleep in bit 9, size code in bits 1:0.
- R2: All other bits read as zero and ignore writes. Writing 0xFFFFFFFF reads back as 0xC7FF0203.
- R3: Any change of `mode_sel` reloads the word with 0x82EE0000 on the next clock edge. The same edge clears the pending refresh request, any running wait and the sleep state, and no sleep exit request is raised.
- R4: `size_code` always equals word bits 1:0 (0/1/2/3 = 64/128/256/512 Mbit).
- R5: Wait lengths in cycles for frequency range 0/1/2/3 (top frequency 15/30/50/100 MHz): power-up (kind 0) 1500/3000/5000/10000, precharge (kind 1) 1/1/1/2, auto-refresh (kind 2) 2/3/4/7. Kind 3 starts nothing.
- R6: A start sampled at clock edge E produces a one-cycle `dly_done` pulse that follows edge E+N, where N is the wait length from R5.
- R7: With refresh count R (0 acts as 1), successive refresh-request rises are R cycles apart, whatever the frequency range.
- R8: `ref_req` stays high until `ref_ack` is sampled high, and falls on that edge. Expiries that happen while a request is still pending are not counted a second time.
- R9: A write that changes sleep from 0 to 1 at edge W raises a one-cycle `sleep_enter` after edge W+1. While asleep, a pending refresh request is dropped and no new one is raised.
- R10: A write that changes sleep from 1 to 0 at edge W raises a one-cycle `sleep_exit` after edge W+1. An auto-refresh wait (R5) follows, then the refresh counter restarts from R, so the first request rises after edge W+1+ARF+R. Writing sleep as 0 while awake raises nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Interface mode selection; any change reloads the configuration |
| cfg_wr_en | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read-back |
| size_code | output | 2 | Memory size code for address decoding |
| ref_ack | input | 1 | Refresh request served |
| ref_req | output | 1 | Periodic refresh request, held until acknowledged |
| dly_start | input | 1 | Start a wait of kind `dly_kind` |
| dly_kind | input | 2 | 0 power-up, 1 precharge, 2 auto-refresh, 3 none |
| dly_done | output | 1 | One-cycle strobe at the end of a wait |
| sleep_enter | output | 1 | One-cycle request to enter self-refresh |
| sleep_exit | output | 1 | One-cycle request to leave self-refresh |

## Verification
The assertions assume that `ref_ack` comes only in reply to a visible request, that `dly_start` is a single-cycle pulse, and that `mode_sel` changes only between transactions and not in the same cycle as a write. The stimulus follows these rules: every input changes on the falling clock edge, each start or write strobe is held for exactly one cycle, an acknowledge is sent only after the bench sees `ref_req` high, and the single mode change is applied while no wait is running.

// File: rtl/sdram_cfg_pkg.sv
package sdram_cfg_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned RFSH_W = 11;
    localparam logic [WORD_W-1:0] CFG_RESET = 32'h82EE_0000;

    typedef enum logic [1:0] {
        SL_RUN   = 2'd0,
        SL_SLEEP = 2'd1,
        SL_WAKE  = 2'd2
    } sleep_st_e;

    typedef struct packed {
        logic [1:0]        freq;
        logic [RFSH_W-1:0] rfsh;
        logic              sleep;
        logic [1:0]        size;
    } cfg_t;

    // Top frequency of each range in MHz: waits are sized for the worst case.
    function automatic int unsigned range_top_mhz(input logic [1:0] r);
        case (r)
            2'd0:    return 15;
            2'd1:    return 30;
            2'd2:    return 50;
            default: return 100;
        endcase
    endfunction

    function automatic int unsigned wait_cycles(input int unsigned ns, input int unsigned mhz);
        return (ns * mhz + 999) / 1000;
    endfunction

    function automatic cfg_t unpack_word(input logic [WORD_W-1:0] w);
        cfg_t c;
        c.freq  = w[31:30];
        c.rfsh  = w[26:16];
        c.sleep = w[9];
        c.size  = w[1:0];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input cfg_t c);
        return {c.freq, 3'b000, c.rfsh, 6'b000000, c.sleep, 7'b0000000, c.size};
    endfunction

endpackage

// File: rtl/sdram_cfg_regs.sv
module sdram_cfg_regs
    import sdram_cfg_pkg::*;
#(
    parameter int unsigned MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output cfg_t              cfg,
    output logic              clr
);

    typedef struct packed {
        cfg_t              cfg;
        logic [MODE_W-1:0] mode;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        clr       = (mode_sel != st_q.mode);
        st_d.mode = mode_sel;
        if (clr) begin
            st_d.cfg = unpack_word(CFG_RESET);
        end else if (wr_en) begin
            st_d.cfg = unpack_word(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg  <= unpack_word(CFG_RESET);
            st_q.mode <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg   = st_q.cfg;
    assign rdata = pack_word(st_q.cfg);

    assert_mode_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (rdata == CFG_RESET));

endmodule

// File: rtl/sdram_delay_unit.sv
module sdram_delay_unit
    import sdram_cfg_pkg::*;
#(
    parameter int unsigned T_PWRUP_NS = 100000,
    parameter int unsigned T_PRE_NS   = 20,
    parameter int unsigned T_ARF_NS   = 70
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic [1:0] freq,
    input  logic       start,
    input  logic [1:0] kind,
    output logic       done
);

    localparam int unsigned MAX_PWRUP = wait_cycles(T_PWRUP_NS, range_top_mhz(2'd3));
    localparam int unsigned MAX_PRE   = wait_cycles(T_PRE_NS, range_top_mhz(2'd3));
    localparam int unsigned MAX_ARF   = wait_cycles(T_ARF_NS, range_top_mhz(2'd3));
    localparam int unsigned MAX_ALL   = (MAX_PWRUP > MAX_ARF)
                                        ? ((MAX_PWRUP > MAX_PRE) ? MAX_PWRUP : MAX_PRE)
                                        : ((MAX_ARF > MAX_PRE) ? MAX_ARF : MAX_PRE);
    localparam int unsigned DLY_W     = $clog2(MAX_ALL + 1);

    typedef struct packed {
        logic [DLY_W-1:0] cnt;
        logic             done;
    } st_t;

    logic [DLY_W-1:0] pwrup_tbl [4];
    logic [DLY_W-1:0] pre_tbl   [4];
    logic [DLY_W-1:0] arf_tbl   [4];
    logic [DLY_W-1:0] load;
    st_t st_d, st_q;

    for (genvar r = 0; r < 4; r++) begin : g_range
        assign pwrup_tbl[r] = DLY_W'(wait_cycles(T_PWRUP_NS, range_top_mhz(2'(r))));
        assign pre_tbl[r]   = DLY_W'(wait_cycles(T_PRE_NS, range_top_mhz(2'(r))));
        assign arf_tbl[r]   = DLY_W'(wait_cycles(T_ARF_NS, range_top_mhz(2'(r))));
    end

    always_comb begin
        case (kind)
            2'd0:    load = pwrup_tbl[freq];
            2'd1:    load = pre_tbl[freq];
            2'd2:    load = arf_tbl[freq];
            default: load = '0;
        endcase
    end

    always_comb begin
        st_d.done = (st_q.cnt == DLY_W'(1));
        st_d.cnt  = (st_q.cnt == '0) ? '0 : st_q.cnt - DLY_W'(1);
        if (start) begin
            st_d.cnt = load;
        end
        if (clr) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done = st_q.done;

    assert_done_after_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !clr && st_q.cnt == DLY_W'(1)) |=> done);

endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer
    import sdram_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [RFSH_W-1:0] rfsh,
    input  logic              suppress,
    input  logic              ack,
    output logic              req
);

    localparam cfg_t CFG_RST = unpack_word(CFG_RESET);

    typedef struct packed {
        logic [RFSH_W-1:0] cnt;
        logic              req;
    } st_t;

    st_t st_d, st_q;
    logic [RFSH_W-1:0] reload;
    logic              expire;

    always_comb begin
        reload = (rfsh == '0) ? RFSH_W'(1) : rfsh;
        expire = (st_q.cnt <= RFSH_W'(1));
        st_d   = st_q;
        if (clr) begin
            st_d.cnt = CFG_RST.rfsh;
            st_d.req = 1'b0;
        end else if (suppress) begin
            st_d.cnt = reload;
            st_d.req = 1'b0;
        end else begin
            st_d.cnt = expire ? reload : st_q.cnt - RFSH_W'(1);
            st_d.req = expire | (st_q.req & ~ack);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= CFG_RST.rfsh;
            st_q.req <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req = st_q.req;

    assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack && !suppress && !clr) |=> req);

    assert_sleep_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        suppress |=> !req);

endmodule

// File: rtl/sdram_sleep_ctrl.sv
module sdram_sleep_ctrl
    import sdram_cfg_pkg::*;
#(
    parameter int unsigned T_ARF_NS = 70
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       sleep,
    input  logic [1:0] freq,
    output logic       enter,
    output logic       exit_req,
    output logic       suppress
);

    localparam int unsigned ARF_W = $clog2(wait_cycles(T_ARF_NS, range_top_mhz(2'd3)) + 1);

    typedef struct packed {
        sleep_st_e        state;
        logic [ARF_W-1:0] cnt;
        logic             enter;
        logic             exit_req;
    } st_t;

    logic [ARF_W-1:0] arf_tbl [4];
    st_t st_d, st_q;

    for (genvar r = 0; r < 4; r++) begin : g_arf
        assign arf_tbl[r] = ARF_W'(wait_cycles(T_ARF_NS, range_top_mhz(2'(r))));
    end

    always_comb begin
        st_d          = st_q;
        st_d.enter    = 1'b0;
        st_d.exit_req = 1'b0;
        case (st_q.state)
            SL_RUN: begin
                if (sleep) begin
                    st_d.state = SL_SLEEP;
                    st_d.enter = 1'b1;
                end
            end
            SL_SLEEP: begin
                if (!sleep) begin
                    st_d.state    = SL_WAKE;
                    st_d.exit_req = 1'b1;
                    st_d.cnt      = arf_tbl[freq];
                end
            end
            SL_WAKE: begin
                if (sleep) begin
                    st_d.state = SL_SLEEP;
                    st_d.enter = 1'b1;
                end else if (st_q.cnt <= ARF_W'(1)) begin
                    st_d.state = SL_RUN;
                end else begin
                    st_d.cnt = st_q.cnt - ARF_W'(1);
                end
            end
            default: st_d.state = SL_RUN;
        endcase
        if (clr) begin
            st_d = '{state: SL_RUN, cnt: '0, enter: 1'b0, exit_req: 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: SL_RUN, cnt: '0, enter: 1'b0, exit_req: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign enter    = st_q.enter;
    assign exit_req = st_q.exit_req;
    assign suppress = (st_q.state != SL_RUN);

    assert_enter_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        enter |=> !enter);

    assert_exit_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        exit_req |=> !exit_req);

    assert_enter_exit_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(enter && exit_req));

endmodule

// File: rtl/sdram_cfg_timer.sv
module sdram_cfg_timer
    import sdram_cfg_pkg::*;
#(
    parameter int unsigned MODE_W     = 2,
    parameter int unsigned T_PWRUP_NS = 100000,
    parameter int unsigned T_PRE_NS   = 20,
    parameter int unsigned T_ARF_NS   = 70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              cfg_wr_en,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic [1:0]        size_code,
    input  logic              ref_ack,
    output logic              ref_req,
    input  logic              dly_start,
    input  logic [1:0]        dly_kind,
    output logic              dly_done,
    output logic              sleep_enter,
    output logic              sleep_exit
);

    cfg_t cfg;
    logic clr;
    logic suppress;

    sdram_cfg_regs #(.MODE_W(MODE_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .wr_en    (cfg_wr_en),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .cfg      (cfg),
        .clr      (clr)
    );

    sdram_delay_unit #(
        .T_PWRUP_NS (T_PWRUP_NS),
        .T_PRE_NS   (T_PRE_NS),
        .T_ARF_NS   (T_ARF_NS)
    ) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .freq  (cfg.freq),
        .start (dly_start),
        .kind  (dly_kind),
        .done  (dly_done)
    );

    sdram_refresh_timer u_refresh (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .rfsh     (cfg.rfsh),
        .suppress (suppress),
        .ack      (ref_ack),
        .req      (ref_req)
    );

    sdram_sleep_ctrl #(.T_ARF_NS(T_ARF_NS)) u_sleep (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .sleep    (cfg.sleep),
        .freq     (cfg.freq),
        .enter    (sleep_enter),
        .exit_req (sleep_exit),
        .suppress (suppress)
    );

    assign size_code = cfg.size;

    assert_clear_quiets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!ref_req && !sleep_exit && !sleep_enter && !dly_done));

endmodule

// File: tb/tb_sdram_cfg_timer.sv
module tb_sdram_cfg_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_sel = 2'd0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [1:0]  size_code;
    logic        ref_ack = 1'b0;
    logic        ref_req;
    logic        dly_start = 1'b0;
    logic [1:0]  dly_kind = 2'd0;
    logic        dly_done;
    logic        sleep_enter;
    logic        sleep_exit;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done_flag = 1'b0;

    typedef struct {
        int    at;
        string tag;
    } exp_t;
    exp_t sbq[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdram_cfg_timer dut (
        .clk (clk), .rst_n (rst_n), .mode_sel (mode_sel),
        .cfg_wr_en (cfg_wr_en), .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata),
        .size_code (size_code), .ref_ack (ref_ack), .ref_req (ref_req),
        .dly_start (dly_start), .dly_kind (dly_kind), .dly_done (dly_done),
        .sleep_enter (sleep_enter), .sleep_exit (sleep_exit)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] w);
        cfg_wr_en = 1'b1;
        cfg_wdata = w;
        @(posedge clk);
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    // Driver: push the expected strobe cycle, then pulse the start.
    task automatic dly(input logic [1:0] kind, input int n, input string tag);
        exp_t e;
        e.at  = cyc + 1 + n;
        e.tag = tag;
        sbq.push_back(e);
        dly_start = 1'b1;
        dly_kind  = kind;
        @(posedge clk);
        @(negedge clk);
        dly_start = 1'b0;
        repeat (n + 2) @(negedge clk);
    endtask

    // Monitor: every strobe pops one expected item.
    always @(negedge clk) begin
        if (rst_n && dly_done) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R6", "unexpected dly_done at cycle", cyc, 0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk(cyc == e.at, "R5/R6", e.tag, cyc, e.at);
            end
        end
    end

    task automatic wait_req(output int t, input int limit);
        t = -1;
        for (int i = 0; i < limit; i++) begin
            if (ref_req) begin
                t = cyc;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic ack_req();
        ref_ack = 1'b1;
        @(negedge clk);
        ref_ack = 1'b0;
    endtask

    int pu[4]  = '{1500, 3000, 5000, 10000};
    int pre[4] = '{1, 1, 1, 2};
    int arf[4] = '{2, 3, 4, 7};

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 200000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int t1, t2, t3, w, rises;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(cfg_rdata == 32'h82EE0000, "R1", "reset word", cfg_rdata, 32'h82EE0000);
        chk(size_code == 2'd0, "R4", "reset size", size_code, 0);
        chk(!ref_req && !sleep_enter && !sleep_exit && !dly_done, "R1", "reset outputs quiet",
            {ref_req, sleep_enter, sleep_exit, dly_done}, 0);

        // R2 / R4: reserved bits and size export
        wr(32'h0000_0002);
        chk(size_code == 2'd2, "R4", "size code 2", size_code, 2);
        wr(32'hFFFF_FFFF);
        chk(cfg_rdata == 32'hC7FF0203, "R2", "all-ones readback", cfg_rdata, 32'hC7FF0203);
        chk(size_code == 2'd3, "R4", "size code 3", size_code, 3);

        // R3: mode change reloads and clears sleep without an exit request
        mode_sel = 2'd1;
        @(negedge clk);
        chk(cfg_rdata == 32'h82EE0000, "R3", "mode change reload", cfg_rdata, 32'h82EE0000);
        rises = 0;
        for (int i = 0; i < 6; i++) begin
            if (sleep_exit || sleep_enter) rises++;
            @(negedge clk);
        end
        chk(rises == 0, "R3", "no sleep strobes after reload", rises, 0);

        // R5 / R6: wait lengths per frequency range
        for (int r = 0; r < 4; r++) begin
            wr({2'(r), 3'b000, 11'h7FF, 16'h0000});
            dly(2'd1, pre[r], $sformatf("precharge range %0d", r));
            dly(2'd2, arf[r], $sformatf("auto-refresh range %0d", r));
            if (r == 0 || r == 3) dly(2'd0, pu[r], $sformatf("power-up range %0d", r));
        end
        dly_start = 1'b1; dly_kind = 2'd3;
        @(negedge clk);
        dly_start = 1'b0;
        repeat (12) @(negedge clk);
        chk(sbq.size() == 0, "R6", "all expected strobes seen", sbq.size(), 0);

        // R7: refresh interval with range 2, then range 0
        if (ref_req) ack_req();
        wr(32'h8014_0000);
        wait_req(t1, 3000); ack_req();
        wait_req(t1, 100);  ack_req();
        wait_req(t2, 100);  ack_req();
        chk(t2 - t1 == 20, "R7", "interval range 2", t2 - t1, 20);
        wr(32'h0014_0000);
        wait_req(t1, 100);  ack_req();
        wait_req(t1, 100);  ack_req();
        wait_req(t2, 100);
        chk(t2 - t1 == 20, "R7", "interval range 0", t2 - t1, 20);

        // R8: held until ack, no second queued request
        t3 = t2;
        while (cyc < t3 + 50) @(negedge clk);
        chk(ref_req == 1'b1, "R8", "request held without ack", ref_req, 1);
        ack_req();
        chk(ref_req == 1'b0, "R8", "ack clears request", ref_req, 0);
        wait_req(t1, 100);
        chk(t1 == t3 + 60, "R8", "next rise only at next expiry", t1, t3 + 60);

        // R9: sleep entry with a pending request
        wr(32'h0014_0200);
        chk(sleep_enter == 1'b0, "R9", "enter not yet", sleep_enter, 0);
        @(negedge clk);
        chk(sleep_enter == 1'b1, "R9", "enter pulse", sleep_enter, 1);
        @(negedge clk);
        chk(sleep_enter == 1'b0, "R9", "enter one cycle", sleep_enter, 0);
        rises = 0;
        for (int i = 0; i < 60; i++) begin
            if (ref_req) rises++;
            @(negedge clk);
        end
        chk(rises == 0, "R9", "no refresh while asleep", rises, 0);

        // R10: wake, wait, resume
        wr(32'h0014_0000);
        w = cyc;
        @(negedge clk);
        chk(sleep_exit == 1'b1, "R10", "exit pulse", sleep_exit, 1);
        wait_req(t1, 100);
        chk(t1 == w + 1 + arf[0] + 20, "R10", "first request after wake", t1, w + 1 + arf[0] + 20);
        ack_req();
        wr(32'h0014_0000);
        rises = 0;
        for (int i = 0; i < 4; i++) begin
            if (sleep_exit) rises++;
            @(negedge clk);
        end
        chk(rises == 0, "R10", "sleep 0 while awake is silent", rises, 0);

        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule